// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is the access engine of a banked on-chip scratchpad shared by the lanes of one warp. A request carries, for every lane, an enable bit, a word address, a write flag and write data. The storage is split into independent word-wide banks, and each bank can serve one address per cycle. The block works out which lanes land on the same bank and serves the colliding lanes over extra cycles. Lanes that avoid each other's banks, such as a unit stride or any one-to-one shuffle of lanes onto banks, are all served in a single cycle.

Within a bank, lanes are served lowest-numbered first. Reads of one identical word that no earlier write in the request can disturb are merged into one service and the value is broadcast. The net effect is that every request behaves as if its enabled lanes ran one after another in ascending lane order. The default build has 16 lanes and 16 banks of 256 32-bit words, which is 16 KB. When the last pending lane is served, the block drops `busy`, pulses `done` and presents the read results on the per-lane response bus.

Top module: `smem_bank_serializer`

## Requirements
- R1: For word address A, the bank is A mod BANKS (the low log2(BANKS) address bits) and the row inside the bank is A / BANKS (the remaining upper bits).
- R2: A request is taken on a rising edge where `req_valid` is high and `busy` is low. A request presented while `busy` is high has no effect on storage or on responses.
- R3: Each bank serves at most one distinct address per cycle. After acceptance, `busy` stays high for max(1, largest number of service groups on any bank) cycles. A service group is one write, or one merged set of reads of the same word.
- R4: A request whose enabled lanes all target different banks, such as stride 1 or any permutation of lanes onto banks, completes with exactly one busy cycle.
- R5: Within a bank, the lowest-numbered pending lane is served first. The final storage and all read results equal those of executing the enabled lanes in ascending lane order, so the highest-numbered writer to a word wins.
- R6: A read lane joins the bank's current winner in the same cycle when three conditions hold: the winner is a read, the address is identical, and no lower-numbered lane still pending on that bank is a write. Such a lane receives the broadcast value without an extra cycle.
- R7: `done` is high for exactly one cycle, on the cycle right after the last service cycle. `busy` goes low at that same edge, and `rsp_rdata` already holds the request's read results.
- R8: The `rsp_rdata` slice of a lane keeps its previous value when that lane is disabled or writes. A request with no lanes enabled takes one busy cycle and then signals `done`.
- R9: After reset, `busy` and `done` are low and every `rsp_rdata` lane is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_lane_en | input | LANES | Per-lane enable |
| req_we | input | LANES | Per-lane write flag |
| req_addr | input | LANES*AW | Per-lane word address, lane l at bits [l*AW +: AW] |
| req_wdata | input | LANES*DW | Per-lane write data, lane l at bits [l*DW +: DW] |
| busy | output | 1 | Request in progress; new requests ignored |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LANES*DW | Per-lane read data, lane l at bits [l*DW +: DW] |

## Verification
The bench builds the block with 8 lanes, 8 banks and 4 rows, which gives a 32-word store. At that size every word can be preloaded and every stride from 1 to 8 can be swept from each of four base addresses. The expected busy cycles for these sweeps come from the greatest-common-divisor pattern of stride against bank count, and the bench models the whole store in lane order. The small space also makes it cheap to run hand-built orderings of writes and reads to one word, disabled-lane masks, a request injected while busy, and a long pseudo-random mix that is checked against the lane-order model.

// File: rtl/smem_bank_serializer.sv
module smem_bank_serializer #(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = $clog2(DEPTH),
  localparam int AW   = BW + RW
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [LANES-1:0]    req_lane_en,
  input  logic [LANES-1:0]    req_we,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [LANES*DW-1:0] rsp_rdata
);

  logic [DW-1:0]    mem [BANKS][DEPTH];
  logic             busy_q, done_q;
  logic [LANES-1:0] pend_q, we_q, serve;
  logic [AW-1:0]    addr_q [LANES];
  logic [DW-1:0]    wdat_q [LANES];
  logic [DW-1:0]    rdat_q [LANES];

  logic [BANKS-1:0] bwe;
  logic [RW-1:0]    brow [BANKS];
  logic [DW-1:0]    bdat [BANKS];

  logic             f_found, f_wseen, f_wwe;
  logic [AW-1:0]    f_wad;

  wire accept = req_valid && !busy_q;
  wire [LANES-1:0] pend_nx = pend_q & ~serve;

  always_comb begin
    serve   = '0;
    bwe     = '0;
    f_found = 1'b0;
    f_wseen = 1'b0;
    f_wwe   = 1'b0;
    f_wad   = '0;
    for (int b = 0; b < BANKS; b++) begin
      brow[b] = '0;
      bdat[b] = '0;
    end
    for (int b = 0; b < BANKS; b++) begin
      f_found = 1'b0;
      f_wseen = 1'b0;
      f_wwe   = 1'b0;
      f_wad   = '0;
      for (int l = 0; l < LANES; l++) begin
        if (busy_q && pend_q[l] && addr_q[l][BW-1:0] == BW'(b)) begin
          if (!f_found) begin
            f_found  = 1'b1;
            serve[l] = 1'b1;
            f_wad    = addr_q[l];
            f_wwe    = we_q[l];
            if (we_q[l]) begin
              bwe[b]  = 1'b1;
              brow[b] = addr_q[l][AW-1:BW];
              bdat[b] = wdat_q[l];
            end
          end else if (!f_wwe && !we_q[l] && !f_wseen && addr_q[l] == f_wad) begin
            serve[l] = 1'b1;
          end
          if (we_q[l]) f_wseen = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      we_q <= req_we;
      for (int l = 0; l < LANES; l++) begin
        addr_q[l] <= req_addr[l*AW +: AW];
        wdat_q[l] <= req_wdata[l*DW +: DW];
      end
    end
    for (int b = 0; b < BANKS; b++)
      if (bwe[b]) mem[b][brow[b]] <= bdat[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
      for (int l = 0; l < LANES; l++) rdat_q[l] <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q <= 1'b1;
          pend_q <= req_lane_en;
        end
      end else begin
        pend_q <= pend_nx;
        for (int l = 0; l < LANES; l++)
          if (serve[l] && !we_q[l])
            rdat_q[l] <= mem[addr_q[l][BW-1:0]][addr_q[l][AW-1:BW]];
        if (pend_nx == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  for (genvar l = 0; l < LANES; l++) begin : g_rsp
    assign rsp_rdata[l*DW +: DW] = rdat_q[l];
  end

endmodule

// File: rtl/smem_bank_serializer_chk.sv
module smem_bank_serializer_chk #(
  parameter int LANES = 16
)(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic [LANES-1:0] pend
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_fall_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pend == '0));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> $stable(pend));

  assert_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend != '0) |=> (pend != $past(pend)));

  assert_no_new_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((pend & ~$past(pend)) == '0));

endmodule

bind smem_bank_serializer smem_bank_serializer_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .busy(busy), .done(done), .pend(pend_q)
);

// File: tb/smem_bank_serializer_bench.sv
module smem_bank_serializer_bench;
  localparam int L  = 8;
  localparam int B  = 8;
  localparam int D  = 4;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int NW = B * D;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [L-1:0] req_lane_en = '0, req_we = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic [L*DW-1:0] req_wdata = '0;
  logic busy, done;
  logic [L*DW-1:0] rsp_rdata;

  smem_bank_serializer #(.LANES(L), .BANKS(B), .DEPTH(D), .DW(DW)) u_smem_bank_serializer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lane_en(req_lane_en),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rsp_rdata(rsp_rdata));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] model [NW];
  logic [DW-1:0] exp_rd [L];
  logic [L-1:0] t_en, t_we;
  logic [AW-1:0] t_ad [L];
  logic [DW-1:0] t_wd [L];
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [DW-1:0] init_val(int a);
    return 32'h1000_0000 + a * 32'h0001_0203;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_passes();
    int best = 1;
    for (int b = 0; b < B; b++) begin
      int cnt = 0;
      for (int l = 0; l < L; l++) begin
        if (t_en[l] && int'(t_ad[l]) % B == b) begin
          bit dup = 0;
          if (!t_we[l])
            for (int k = 0; k < l; k++)
              if (t_en[k] && !t_we[k] && t_ad[k] == t_ad[l]) dup = 1;
          if (!dup) cnt++;
        end
      end
      if (cnt > best) best = cnt;
    end
    return best;
  endfunction

  task automatic apply_model();
    for (int l = 0; l < L; l++)
      if (t_en[l]) begin
        if (t_we[l]) model[t_ad[l]] = t_wd[l];
        else exp_rd[l] = model[t_ad[l]];
      end
  endtask

  task automatic go(input int exp_cyc, input string tag, input bit inject);
    int cyc = 0;
    int pc = 0;
    @(negedge clk);
    req_valid   = 1;
    req_lane_en = t_en;
    req_we      = t_we;
    for (int l = 0; l < L; l++) begin
      req_addr[l*AW +: AW]  = t_ad[l];
      req_wdata[l*DW +: DW] = t_wd[l];
    end
    @(negedge clk);
    if (inject) begin
      req_we = '1;
      req_lane_en = '1;
      for (int l = 0; l < L; l++) begin
        req_addr[l*AW +: AW]  = 5'd9;
        req_wdata[l*DW +: DW] = 32'hDEAD_0000 + l;
      end
    end else req_valid = 0;
    while (!done && cyc < 100) begin
      if (busy) cyc++;
      @(negedge clk);
    end
    req_valid = 0;
    apply_model();
    for (int l = 0; l < L; l++) if (t_en[l]) pc++;
    if (exp_cyc > 0)
      chk(cyc == exp_cyc, {tag, " busy cycles"}, cyc, exp_cyc);
    else
      chk(cyc >= 1 && cyc <= (pc > 0 ? pc : 1), {tag, " busy cycles bound"}, cyc, pc);
    for (int l = 0; l < L; l++)
      chk(rsp_rdata[l*DW +: DW] === exp_rd[l], {tag, " lane data"}, rsp_rdata[l*DW +: DW], exp_rd[l]);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R7 done single pulse", {30'd0, busy, done}, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    for (int l = 0; l < L; l++) exp_rd[l] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R9 reset flags", {30'd0, busy, done}, 0);
    chk(rsp_rdata == '0, "R9 reset rdata", rsp_rdata[31:0], 0);
    rst_n = 1;

    // R4 R1: fill store, stride 1 writes
    for (int c = 0; c < D; c++) begin
      t_en = '1; t_we = '1;
      for (int l = 0; l < L; l++) begin
        t_ad[l] = AW'(c * B + l);
        t_wd[l] = init_val(c * B + l);
      end
      go(1, "R4 stride1 write", 0);
    end

    // R1 R3 R4: read stride sweep
    for (int s = 1; s <= 8; s++)
      for (int b = 0; b < 4; b++) begin
        t_en = '1; t_we = '0;
        for (int l = 0; l < L; l++) begin
          t_ad[l] = AW'((b + l * s) % NW);
          t_wd[l] = '0;
        end
        go(exp_passes(), "R1 R3 stride read", 0);
      end

    // R4: permutation onto banks
    t_en = '1; t_we = '0;
    for (int l = 0; l < L; l++) t_ad[l] = AW'(((l * 3 + 1) % B) + B * ((l * 5) % D));
    go(1, "R4 permutation", 0);

    // R6: all lanes read one word
    for (int l = 0; l < L; l++) t_ad[l] = 5'd13;
    go(1, "R6 broadcast read", 0);

    // R5 R3: all lanes write one word, highest lane wins
    t_we = '1;
    for (int l = 0; l < L; l++) begin t_ad[l] = 5'd5; t_wd[l] = 32'hAB00_0000 + l; end
    go(8, "R5 same-word writes", 0);
    t_we = '0;
    go(1, "R5 readback last writer", 0);
    chk(exp_rd[0] == 32'hAB00_0007, "R5 model winner", exp_rd[0], 32'hAB00_0007);

    // R5 R6: lane0 write, others read after it
    t_we = 8'h01;
    for (int l = 0; l < L; l++) begin t_ad[l] = 5'd20; t_wd[l] = 32'hC0DE_0001; end
    go(2, "R5 R6 write then reads", 0);
    // R6: reads ahead of lane7 write see old value
    t_we = 8'h80; t_wd[7] = 32'hC0DE_0002;
    go(2, "R6 reads then write", 0);
    // R6: write in the middle splits the broadcast
    t_we = 8'h08; t_wd[3] = 32'hC0DE_0003;
    go(3, "R6 write splits broadcast", 0);

    // R8: disabled lanes keep data
    t_en = 8'h55; t_we = '0;
    for (int l = 0; l < L; l++) t_ad[l] = AW'(l + 24);
    go(1, "R8 partial enable", 0);
    // R8: write lanes keep data
    t_en = '1; t_we = 8'hF0;
    for (int l = 0; l < L; l++) begin t_ad[l] = AW'(l + 8); t_wd[l] = 32'h5A5A_0000 + l; end
    go(1, "R8 write lanes hold", 0);
    // R8: empty request
    t_en = '0;
    go(1, "R8 empty request", 0);

    // R2: request while busy ignored
    t_en = '1; t_we = '1;
    for (int l = 0; l < L; l++) begin t_ad[l] = 5'd6; t_wd[l] = 32'h7700_0000 + l; end
    go(8, "R2 busy request", 1);
    t_en = 8'h03; t_we = '0; t_ad[0] = 5'd9; t_ad[1] = 5'd6;
    go(1, "R2 ignored write absent", 0);

    // R5 R6 R3: pseudo-random mix
    for (int n = 0; n < 300; n++) begin
      for (int l = 0; l < L; l++) begin
        rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
        t_ad[l] = (n % 3 == 0) ? AW'(rng[2:0] * 8) : rng[AW-1:0];
        t_we[l] = rng[8] & rng[9];
        t_en[l] = rng[10] | rng[11];
        t_wd[l] = rng;
      end
      go(0, "R5 random mix", 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule